// File: doc/BRIEF.md
# Character Serializer and Deserializer with Reversible Bit Order

This block moves one character of 4 to 16 bits over a single serial data line, one bit per clock cycle, and rebuilds it on the receiving side. A one-cycle load strobe hands the transmitter a data word, a character length and an order flag. The transmitter then drives one bit per cycle and marks each bit as valid. It raises a one-cycle done pulse after the last bit has left.

With the order flag clear, the character goes out least significant bit first. That means the lower byte is sent first, followed by the remaining upper bits. With the flag set, the character is first mirrored over its programmed length. The mirrored value is then sent most significant bit first within each byte, lower byte first. For characters of 8 bits or fewer the line is a single partial byte. The receiver uses the same position map in the other direction, so a loopback returns the original word for any length and either order.

Top module: `char_serdes`

## Requirements
- R1: The effective length L is the programmed length limited to the range 4 to 16: values below 4 act as 4 and values above 16 act as 16. A load accepted while idle makes `tx_sdo_valid` high from the next cycle for exactly L cycles.
- R2: With `tx_rev` = 0, the k-th bit on the line (k counted from 0) is data bit k.
- R3: With `tx_rev` = 1 and L > 8, bits k = 0..7 on the line carry data bit L-8+k, and bits k = 8..L-1 carry data bit k-8. For L = 16 this sends the upper data byte first, least significant bit first.
- R4: With `tx_rev` = 1 and L <= 8, the line carries the same sequence as with `tx_rev` = 0.
- R5: Data bits at positions L and above never reach the line.
- R6: `tx_done` is high for exactly one cycle, the cycle right after the last valid bit, and `tx_sdo_valid` is low in that cycle. A load presented in that cycle is accepted.
- R7: A load presented while a character is being shifted is ignored: the running character completes unchanged with its original length.
- R8: After L valid bits, the receiver raises `rx_done` for one cycle and presents on `rx_data` the word rebuilt through the inverse of the R2 to R4 map, with every bit at position L and above zero. Its length and order are taken at the first valid bit of each character.
- R9: Reset is synchronous and active low. It returns `tx_sdo`, `tx_sdo_valid`, `tx_done`, `rx_done` and `rx_data` to zero and abandons any character in progress. `tx_sdo` is low whenever `tx_sdo_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_load | input | 1 | Load strobe for a new character |
| tx_data | input | 16 | Character to send (bits at positions L and above are ignored) |
| tx_len | input | 5 | Programmed character length |
| tx_rev | input | 1 | Order flag: 0 = plain, 1 = mirrored |
| tx_sdo | output | 1 | Serial data out |
| tx_sdo_valid | output | 1 | High while `tx_sdo` carries a bit |
| tx_done | output | 1 | One-cycle pulse after the last bit |
| rx_valid | input | 1 | Receive bit strobe |
| rx_sdi | input | 1 | Serial data in |
| rx_len | input | 5 | Programmed receive length |
| rx_rev | input | 1 | Receive order flag |
| rx_data | output | 16 | Last rebuilt character |
| rx_done | output | 1 | One-cycle pulse when `rx_data` updates |

## Verification
A 16-bit word with distinct bytes, 0x1234, tells the plain order apart from the byte-swapped mirrored order. The 9, 12 and 13 bit characters have an uneven split between the two bytes, so they expose any error in the L-8 offset. Patterns with ones above the programmed length show whether unused bits leak onto the line or into the rebuilt word. Short characters sent with both settings of the order flag confirm that a single partial byte is unaffected by the flag. Lengths of 3 and 20 exercise the clamp. Every character is looped back into the receiver, which checks the inverse map against the word that was sent.

// File: rtl/char_serdes_pkg.sv
// Shared definitions for the character serializer/deserializer.
// Assumes characters are split into 8-bit groups, at most two of them.
package char_serdes_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        ORDER_PLAIN  = 1'b0,
        ORDER_MIRROR = 1'b1
    } order_e;
endpackage

// File: rtl/char_len_clamp.sv
// Limits a raw programmed length to the supported range [MIN_LEN, MAX_LEN].
// Assumes MIN_LEN <= MAX_LEN and both fit in LEN_W bits.
module char_len_clamp #(
    parameter int unsigned MIN_LEN = 4,
    parameter int unsigned MAX_LEN = 16,
    parameter int unsigned LEN_W   = 5
) (
    input  logic [LEN_W-1:0] raw_len,
    output logic [LEN_W-1:0] eff_len
);
    localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] HI = LEN_W'(MAX_LEN);

    // Saturate below and above the legal range.
    always_comb begin
        if (raw_len < LO)      eff_len = LO;
        else if (raw_len > HI) eff_len = HI;
        else                   eff_len = raw_len;
    end
endmodule

// File: rtl/char_bit_map.sv
// Maps a line position (0 = first bit on the wire) to the data bit index.
// Plain order or length <= one byte: identity. Mirrored order with a longer
// character: the first byte carries data bits L-8..L-1, the rest 0..L-9.
// Assumes len is already clamped and pos < len.
module char_bit_map
    import char_serdes_pkg::*;
#(
    parameter int unsigned LEN_W = 5,
    parameter int unsigned IDX_W = 4
) (
    input  logic [LEN_W-1:0] len,
    input  order_e           order,
    input  logic [IDX_W-1:0] pos,
    output logic [IDX_W-1:0] idx
);
    localparam logic [LEN_W-1:0] BYTE_L = LEN_W'(BYTE_W);
    localparam logic [IDX_W-1:0] BYTE_I = IDX_W'(BYTE_W);

    logic [LEN_W:0] hi_sum;

    // Select the data index for the current line position.
    always_comb begin
        hi_sum = {1'b0, len} - (LEN_W+1)'(BYTE_W) + (LEN_W+1)'(pos);
        if (order == ORDER_PLAIN || len <= BYTE_L) idx = pos;
        else if (pos < BYTE_I)                     idx = hi_sum[IDX_W-1:0];
        else                                       idx = pos - BYTE_I;
    end
endmodule

// File: rtl/char_tx.sv
// Transmit shifter: captures a character on a load while idle, then drives
// one bit per cycle for len cycles, followed by a one-cycle done pulse.
// Loads arriving while a character is in flight are dropped.
module char_tx
    import char_serdes_pkg::*;
#(
    parameter int unsigned MAX_LEN = 16,
    parameter int unsigned LEN_W   = 5,
    parameter int unsigned IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [MAX_LEN-1:0] data,
    input  logic [LEN_W-1:0]   len,
    input  logic               rev,
    output logic               sdo,
    output logic               sdo_valid,
    output logic               done
);
    logic [MAX_LEN-1:0] word_q;
    logic [LEN_W-1:0]   len_q;
    order_e             order_q;
    logic [IDX_W-1:0]   pos_q;
    logic               active_q;
    logic               done_q;
    logic [IDX_W-1:0]   idx;
    logic               last;

    char_bit_map #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_map (
        .len   (len_q),
        .order (order_q),
        .pos   (pos_q),
        .idx   (idx)
    );

    // Flag the final bit of the running character.
    assign last = (LEN_W'(pos_q) == len_q - LEN_W'(1));

    // Capture, advance and finish a character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            len_q    <= '0;
            order_q  <= ORDER_PLAIN;
            pos_q    <= '0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (load) begin
                    word_q   <= data;
                    len_q    <= len;
                    order_q  <= order_e'(rev);
                    pos_q    <= '0;
                    active_q <= 1'b1;
                end
            end else if (last) begin
                active_q <= 1'b0;
                done_q   <= 1'b1;
            end else begin
                pos_q <= pos_q + IDX_W'(1);
            end
        end
    end

    // Drive the mapped bit only while shifting.
    assign sdo       = active_q & word_q[idx];
    assign sdo_valid = active_q;
    assign done      = done_q;
endmodule

// File: rtl/char_rx.sv
// Receive assembler: places each valid bit at the data index given by the
// shared map, and publishes the rebuilt word with a one-cycle done pulse.
// Length and order are sampled at the first bit of every character.
module char_rx
    import char_serdes_pkg::*;
#(
    parameter int unsigned MAX_LEN = 16,
    parameter int unsigned LEN_W   = 5,
    parameter int unsigned IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic               sdi,
    input  logic [LEN_W-1:0]   len,
    input  logic               rev,
    output logic [MAX_LEN-1:0] word,
    output logic               done
);
    logic [MAX_LEN-1:0] shadow_q;
    logic [MAX_LEN-1:0] word_q;
    logic [LEN_W-1:0]   len_q;
    order_e             order_q;
    logic [IDX_W-1:0]   pos_q;
    logic               done_q;
    logic [LEN_W-1:0]   cfg_len;
    order_e             cfg_order;
    logic [IDX_W-1:0]   idx;
    logic [MAX_LEN-1:0] fill;
    logic               last;

    char_bit_map #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_map (
        .len   (cfg_len),
        .order (cfg_order),
        .pos   (pos_q),
        .idx   (idx)
    );

    // Pick live or held configuration and merge the incoming bit.
    always_comb begin
        cfg_len   = (pos_q == '0) ? len : len_q;
        cfg_order = (pos_q == '0) ? order_e'(rev) : order_q;
        fill      = (pos_q == '0) ? '0 : shadow_q;
        fill[idx] = sdi;
        last      = (LEN_W'(pos_q) == cfg_len - LEN_W'(1));
    end

    // Collect bits and publish the finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            word_q   <= '0;
            len_q    <= '0;
            order_q  <= ORDER_PLAIN;
            pos_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (valid) begin
                len_q   <= cfg_len;
                order_q <= cfg_order;
                if (last) begin
                    word_q <= fill;
                    done_q <= 1'b1;
                    pos_q  <= '0;
                end else begin
                    shadow_q <= fill;
                    pos_q    <= pos_q + IDX_W'(1);
                end
            end
        end
    end

    assign word = word_q;
    assign done = done_q;
endmodule

// File: rtl/char_serdes.sv
// Top level: a clamped-length transmit shifter and a matching receive
// assembler sharing one line-position map. The two directions are
// independent; a loopback is formed outside the block.
module char_serdes #(
    parameter int unsigned MIN_LEN = 4,
    parameter int unsigned MAX_LEN = 16,
    localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
    localparam int unsigned IDX_W  = $clog2(MAX_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_load,
    input  logic [MAX_LEN-1:0] tx_data,
    input  logic [LEN_W-1:0]   tx_len,
    input  logic               tx_rev,
    output logic               tx_sdo,
    output logic               tx_sdo_valid,
    output logic               tx_done,
    input  logic               rx_valid,
    input  logic               rx_sdi,
    input  logic [LEN_W-1:0]   rx_len,
    input  logic               rx_rev,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               rx_done
);
    logic [LEN_W-1:0] tx_eff_len;
    logic [LEN_W-1:0] rx_eff_len;

    char_len_clamp #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_tx_clamp (
        .raw_len (tx_len),
        .eff_len (tx_eff_len)
    );

    char_len_clamp #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_rx_clamp (
        .raw_len (rx_len),
        .eff_len (rx_eff_len)
    );

    char_tx #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .data      (tx_data),
        .len       (tx_eff_len),
        .rev       (tx_rev),
        .sdo       (tx_sdo),
        .sdo_valid (tx_sdo_valid),
        .done      (tx_done)
    );

    char_rx #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (rx_valid),
        .sdi   (rx_sdi),
        .len   (rx_eff_len),
        .rev   (rx_rev),
        .word  (rx_data),
        .done  (rx_done)
    );
endmodule

// File: rtl/char_serdes_chk.sv
// Temporal checks on the ports of char_serdes. Keeps its own count of
// consecutive valid cycles so that the length bound needs no deep history.
module char_serdes_chk #(
    parameter int unsigned MAX_LEN = 16,
    localparam int unsigned RUN_W  = $clog2(MAX_LEN + 1) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic tx_load,
    input logic tx_sdo,
    input logic tx_sdo_valid,
    input logic tx_done,
    input logic rx_done
);
    logic [RUN_W-1:0] run_q;

    // Count valid cycles already seen in the current character.
    always_ff @(posedge clk) begin
        if (!rst_n)            run_q <= '0;
        else if (tx_sdo_valid) run_q <= run_q + RUN_W'(1);
        else                   run_q <= '0;
    end

    // R1
    tx_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sdo_valid |-> run_q < RUN_W'(MAX_LEN));

    // R1
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !tx_sdo_valid) |=> tx_sdo_valid);

    // R6
    tx_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    // R6
    tx_done_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!tx_sdo_valid && $past(tx_sdo_valid)));

    // R8
    rx_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R9
    tx_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_sdo_valid |-> !tx_sdo);
endmodule

bind char_serdes char_serdes_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_load      (tx_load),
    .tx_sdo       (tx_sdo),
    .tx_sdo_valid (tx_sdo_valid),
    .tx_done      (tx_done),
    .rx_done      (rx_done)
);

// File: tb/char_serdes_test.sv
`timescale 1ns/1ps
module char_serdes_test;
    typedef struct packed {
        logic [15:0] data;
        logic [4:0]  len;
        logic        rev;
        logic [15:0] exp_line;
        logic [4:0]  exp_bits;
    } vec_t;

    // Line words: bit k holds the k-th bit seen on tx_sdo.
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'h00A5, 5'd8,  1'b0, 16'h00A5, 5'd8 },  // R2
        '{16'h00A5, 5'd8,  1'b1, 16'h00A5, 5'd8 },  // R4
        '{16'h000B, 5'd4,  1'b0, 16'h000B, 5'd4 },  // R2
        '{16'hFFFB, 5'd4,  1'b1, 16'h000B, 5'd4 },  // R4 R5
        '{16'h1234, 5'd16, 1'b0, 16'h1234, 5'd16},  // R2
        '{16'h1234, 5'd16, 1'b1, 16'h3412, 5'd16},  // R3
        '{16'hFABC, 5'd13, 1'b0, 16'h1ABC, 5'd13},  // R5
        '{16'h1ABC, 5'd13, 1'b1, 16'h1CD5, 5'd13},  // R3
        '{16'hFABC, 5'd13, 1'b1, 16'h1CD5, 5'd13},  // R3 R5
        '{16'h0155, 5'd9,  1'b1, 16'h01AA, 5'd9 },  // R3
        '{16'h0ABC, 5'd12, 1'b1, 16'h0CAB, 5'd12},  // R3
        '{16'h00FF, 5'd3,  1'b0, 16'h000F, 5'd4 },  // R1 clamp low
        '{16'hFFFF, 5'd20, 1'b0, 16'hFFFF, 5'd16}   // R1 clamp high
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_load = 1'b0;
    logic [15:0] tx_data = '0;
    logic [4:0]  tx_len = 5'd8;
    logic        tx_rev = 1'b0;
    logic        tx_sdo, tx_sdo_valid, tx_done;
    logic [15:0] rx_data;
    logic        rx_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    char_serdes uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_load      (tx_load),
        .tx_data      (tx_data),
        .tx_len       (tx_len),
        .tx_rev       (tx_rev),
        .tx_sdo       (tx_sdo),
        .tx_sdo_valid (tx_sdo_valid),
        .tx_done      (tx_done),
        .rx_valid     (tx_sdo_valid),
        .rx_sdi       (tx_sdo),
        .rx_len       (tx_len),
        .rx_rev       (tx_rev),
        .rx_data      (rx_data),
        .rx_done      (rx_done)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] low_mask(input int bits);
        logic [15:0] m = '0;
        for (int i = 0; i < bits; i++) m[i] = 1'b1;
        return m;
    endfunction

    // Present a one-cycle load; returns at the negedge after the capture edge.
    task automatic pulse_load(input logic [15:0] d, input logic [4:0] l, input logic r);
        tx_load = 1'b1; tx_data = d; tx_len = l; tx_rev = r;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // Record the line until valid falls; ends at the done cycle.
    task automatic capture(output logic [15:0] line, output int nbits);
        line = '0; nbits = 0;
        while (tx_sdo_valid && nbits < 40) begin
            if (nbits < 16) line[nbits] = tx_sdo;
            nbits++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] line;
        int nbits;

        // R9 reset state, with a load held during reset
        tx_load = 1'b1; tx_data = 16'hFFFF;
        repeat (3) @(negedge clk);
        tx_load = 1'b0;
        check("R9 reset valid", {31'd0, tx_sdo_valid}, 0);
        check("R9 reset sdo", {31'd0, tx_sdo}, 0);
        check("R9 reset done", {31'd0, tx_done}, 0);
        check("R9 reset rx_data", {16'd0, rx_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle after reset", {31'd0, tx_sdo_valid}, 0);

        // Vector table: line order, length, done and loopback
        for (int v = 0; v < NV; v++) begin
            pulse_load(VECS[v].data, VECS[v].len, VECS[v].rev);
            capture(line, nbits);
            check($sformatf("R2 R3 R4 R5 line v%0d", v), {16'd0, line}, {16'd0, VECS[v].exp_line});
            check($sformatf("R1 bits v%0d", v), nbits, {27'd0, VECS[v].exp_bits});
            check($sformatf("R6 done v%0d", v), {31'd0, tx_done}, 1);
            check($sformatf("R8 rx_done v%0d", v), {31'd0, rx_done}, 1);
            check($sformatf("R8 rx_data v%0d", v), {16'd0, rx_data},
                  {16'd0, VECS[v].data & low_mask(int'(VECS[v].exp_bits))});
            @(negedge clk);
            check($sformatf("R6 done width v%0d", v), {31'd0, tx_done}, 0);
        end

        // R7 load while busy is ignored
        pulse_load(16'h1234, 5'd16, 1'b0);
        line = '0; nbits = 0;
        while (tx_sdo_valid && nbits < 40) begin
            if (nbits < 16) line[nbits] = tx_sdo;
            nbits++;
            if (nbits == 3) begin tx_load = 1'b1; tx_data = 16'hFFFF; tx_len = 5'd4; end
            if (nbits == 5) tx_load = 1'b0;
            @(negedge clk);
        end
        tx_load = 1'b0;
        check("R7 line kept", {16'd0, line}, 32'h1234);
        check("R7 length kept", nbits, 16);
        check("R7 rx word", {16'd0, rx_data}, 32'h1234);
        repeat (2) @(negedge clk);
        check("R7 no late start", {31'd0, tx_sdo_valid}, 0);

        // R6 back-to-back load in the done cycle
        pulse_load(16'h00C3, 5'd8, 1'b0);
        capture(line, nbits);
        check("R6 done before reload", {31'd0, tx_done}, 1);
        pulse_load(16'h0ABC, 5'd12, 1'b1);
        check("R6 reload accepted", {31'd0, tx_sdo_valid}, 1);
        capture(line, nbits);
        check("R6 reload line R3", {16'd0, line}, 32'h0CAB);
        check("R8 reload rx", {16'd0, rx_data}, 32'h0ABC);

        // R9 reset mid-character
        pulse_load(16'h1234, 5'd16, 1'b1);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset valid", {31'd0, tx_sdo_valid}, 0);
        check("R9 mid reset rx_data", {16'd0, rx_data}, 0);
        check("R9 mid reset sdo", {31'd0, tx_sdo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        pulse_load(16'h1ABC, 5'd13, 1'b1);
        capture(line, nbits);
        check("R9 clean restart line", {16'd0, line}, 32'h1CD5);
        check("R9 clean restart rx", {16'd0, rx_data}, 32'h1ABC);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule